// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a DDR-style SDRAM from reset to a usable state without help from a processor. After the start input is seen, it raises the clock-enable level. It then issues a fixed series of commands on a single-phase command interface: a chip-select strobe, row, column and write-enable strobes (all active low), a row/mode address bus and a bank address. The series is precharge-all, extended mode load, mode load with DLL reset, a second precharge-all, two auto-refreshes, and a final mode load without DLL reset.

Each step is followed by its own programmable quiet interval. A single down-counter in the datapath times every interval. A small control machine walks the steps and hands the datapath one issue strobe and a step index. After the last interval the done output rises, and it stays high until reset. No further command is ever issued after that.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is applied, and after reset until a start is seen, cke is 0, done is 0, the strobes show the deselect code {csN,rasN,casN,weN}=4'b1111, and addr and bank are 0.
- R2: In the cycle after the clock edge that samples start high in the idle state, cke reads 1 and no command is issued. Once high, cke stays high until reset.
- R3: Every command (csN low) lasts exactly one clock. csN is high in the following cycle.
- R4: Precharge-all is {csN,rasN,casN,weN}=4'b0010 with addr=0x0400 (bit 10 set) and bank=0.
- R5: The extended mode load is 4'b0000 with bank=1 and addr=0x0000.
- R6: The first mode load is 4'b0000 with bank=0 and addr=0x0132 (DLL reset, CAS latency 3, burst 4), followed by WAIT_MODE quiet cycles (default 200).
- R7: After the second precharge-all, exactly two auto-refreshes (4'b0001, addr=0, bank=0) are issued, each followed by WAIT_REF quiet cycles (default 4).
- R8: The final command is a mode load with bank=0 and addr=0x0032 (no DLL reset). done rises after the WAIT_MODE quiet cycles that follow it.
- R9: The order is fixed: cke rise, precharge-all, extended mode, mode with DLL reset, precharge-all, refresh, refresh, mode. There are exactly seven commands per run.
- R10: After a step with wait W, exactly W deselect cycles pass before the next command (or before done), so the next event is W+1 cycles later. The cke step waits WAIT_CKE, each precharge WAIT_PRE, and the extended mode load WAIT_EXT.
- R11: done stays high until reset, and no command is issued while done is high.
- R12: start is ignored while the sequence runs and after done. Reset during a run returns the block to the R1 state, and a new start replays the full sequence.
- R13: Whenever csN is high, addr and bank are driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the sequence when the block is idle |
| csN | output | 1 | Chip select strobe, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write-enable strobe, active low |
| addr | output | ADDR_W | Row / mode-register address |
| bank | output | BANK_W | Bank address |
| cke | output | 1 | Clock-enable level to the memory |
| done | output | 1 | Sequence complete, held until reset |

## Verification
The bench logs every command with its cycle stamp. It compares the full list of seven encodings, addresses, banks and gaps against values computed from the wait parameters, which exposes any off-by-one in the single shared counter: such a design shifts every later stamp by one or more cycles. A start pulse during the 200-cycle mode wait and another after done catch a controller that restarts or re-issues commands, because the log then holds more than seven entries. A reset in the middle of the series, followed by a fresh full run, catches state that survives reset, such as a step index left behind or a cke that stays high.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // strobe code ordered {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_DESELECT  = 4'b1111,
    CMD_PRECHARGE = 4'b0010,
    CMD_LOAD_MODE = 4'b0000,
    CMD_REFRESH   = 4'b0001
  } sdramCmd_e;

  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [STEP_W-1:0] {
    stepCke, stepPreA, stepExtMode, stepModeDll,
    stepPreB, stepRefA, stepRefB, stepModeRun
  } initStep_e;

  typedef struct packed {
    logic      issue;
    initStep_e step;
  } seqStrobe_t;

  localparam logic [15:0] ADDR_PRE_ALL  = 16'h0400;
  localparam logic [15:0] ADDR_MODE_DLL = 16'h0132;
  localparam logic [15:0] ADDR_MODE_RUN = 16'h0032;

  function automatic sdramCmd_e stepCommand(initStep_e s);
    case (s)
      stepPreA, stepPreB:                    return CMD_PRECHARGE;
      stepExtMode, stepModeDll, stepModeRun: return CMD_LOAD_MODE;
      stepRefA, stepRefB:                    return CMD_REFRESH;
      default:                               return CMD_DESELECT;
    endcase
  endfunction

  function automatic logic [15:0] stepAddress(initStep_e s);
    case (s)
      stepPreA, stepPreB: return ADDR_PRE_ALL;
      stepModeDll:        return ADDR_MODE_DLL;
      stepModeRun:        return ADDR_MODE_RUN;
      default:            return 16'h0000;
    endcase
  endfunction

  function automatic logic [1:0] stepBank(initStep_e s);
    return (s == stepExtMode) ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 2,
  parameter int WAIT_CKE  = 10,
  parameter int WAIT_PRE  = 2,
  parameter int WAIT_EXT  = 2,
  parameter int WAIT_MODE = 200,
  parameter int WAIT_REF  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic [3:0]        cmdOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BANK_W-1:0] bankOut,
  output logic              ckeOut,
  output logic              waitDone
);

  localparam int MAX_A = (WAIT_CKE > WAIT_PRE) ? WAIT_CKE : WAIT_PRE;
  localparam int MAX_B = (WAIT_EXT > WAIT_REF) ? WAIT_EXT : WAIT_REF;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_WAIT = (MAX_C > WAIT_MODE) ? MAX_C : WAIT_MODE;
  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  generate
    if (ADDR_W < 11) begin : g_addrTooNarrow
      $error("ADDR_W must reach bit 10 for precharge-all");
    end
    if (BANK_W < 1) begin : g_bankTooNarrow
      $error("BANK_W must be at least 1");
    end
    if (WAIT_CKE < 1 || WAIT_PRE < 1 || WAIT_EXT < 1 || WAIT_MODE < 1 || WAIT_REF < 1)
    begin : g_waitTooShort
      $error("every wait must be at least one cycle");
    end
  endgenerate

  function automatic logic [CNT_W-1:0] waitFor(initStep_e s);
    case (s)
      stepCke:                  return CNT_W'(WAIT_CKE);
      stepPreA, stepPreB:       return CNT_W'(WAIT_PRE);
      stepExtMode:              return CNT_W'(WAIT_EXT);
      stepRefA, stepRefB:       return CNT_W'(WAIT_REF);
      default:                  return CNT_W'(WAIT_MODE);
    endcase
  endfunction

  logic [CNT_W-1:0]  waitCnt;
  logic [3:0]        cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic [BANK_W-1:0] bankQ;
  logic              ckeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= CMD_DESELECT;
      addrQ   <= '0;
      bankQ   <= '0;
      ckeQ    <= 1'b0;
      waitCnt <= '0;
    end else if (strobe.issue) begin
      cmdQ    <= stepCommand(strobe.step);
      addrQ   <= ADDR_W'(stepAddress(strobe.step));
      bankQ   <= BANK_W'(stepBank(strobe.step));
      waitCnt <= waitFor(strobe.step);
      if (strobe.step == stepCke) ckeQ <= 1'b1;
    end else begin
      cmdQ  <= CMD_DESELECT;
      addrQ <= '0;
      bankQ <= '0;
      if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cmdOut   = cmdQ;
  assign addrOut  = addrQ;
  assign bankOut  = bankQ;
  assign ckeOut   = ckeQ;
  assign waitDone = (waitCnt == '0);

  assert_one_cycle_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cmdQ[3] |=> cmdQ[3]);

  assert_nop_bus_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    cmdQ[3] |-> (addrQ == '0 && bankQ == '0));

  assert_pre_a10_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_PRECHARGE) |-> (addrQ[10] && bankQ == '0));

  assert_ext_mode_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_LOAD_MODE && bankQ == BANK_W'(1)) |-> (addrQ == '0));

  assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    ckeQ |=> ckeQ);

  assert_no_issue_in_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    (waitCnt != '0) |=> cmdQ[3]);

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       waitDone,
  output seqStrobe_t strobe,
  output logic       done
);

  typedef enum logic [1:0] {sIdle, sRun, sDone} ctrlState_e;

  ctrlState_e state;
  initStep_e  stepQ;
  initStep_e  stepNext;
  logic       lastStep;

  assign stepNext = initStep_e'(stepQ + 1'b1);
  assign lastStep = (stepQ == stepModeRun);

  always_comb begin
    strobe.issue = 1'b0;
    strobe.step  = stepQ;
    case (state)
      sIdle: if (start) begin
        strobe.issue = 1'b1;
        strobe.step  = stepCke;
      end
      sRun: if (waitDone && !lastStep) begin
        strobe.issue = 1'b1;
        strobe.step  = stepNext;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= sIdle;
      stepQ <= stepCke;
    end else begin
      case (state)
        sIdle: if (start) begin
          state <= sRun;
          stepQ <= stepCke;
        end
        sRun: if (waitDone) begin
          if (lastStep) state <= sDone;
          else          stepQ <= stepNext;
        end
        default: ;
      endcase
    end
  end

  assign done = (state == sDone);

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(stepQ) == stepModeRun));

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state != sIdle && !waitDone) |-> !strobe.issue);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 2,
  parameter int WAIT_CKE  = 10,
  parameter int WAIT_PRE  = 2,
  parameter int WAIT_EXT  = 2,
  parameter int WAIT_MODE = 200,
  parameter int WAIT_REF  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              cke,
  output logic              done
);

  seqStrobe_t strobe;
  logic       waitDone;
  logic [3:0] cmdBits;

  sdram_init_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .waitDone (waitDone),
    .strobe   (strobe),
    .done     (done)
  );

  sdram_init_dp #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .WAIT_CKE  (WAIT_CKE),
    .WAIT_PRE  (WAIT_PRE),
    .WAIT_EXT  (WAIT_EXT),
    .WAIT_MODE (WAIT_MODE),
    .WAIT_REF  (WAIT_REF)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdOut   (cmdBits),
    .addrOut  (addr),
    .bankOut  (bank),
    .ckeOut   (cke),
    .waitDone (waitDone)
  );

  assign {csN, rasN, casN, weN} = cmdBits;

  assert_quiet_before_cke_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (csN && !done));

  assert_no_cmd_after_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && cke));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int W_CKE  = 10;
  localparam int W_PRE  = 2;
  localparam int W_EXT  = 2;
  localparam int W_MODE = 200;
  localparam int W_REF  = 4;
  localparam int NCMD   = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic csN, rasN, casN, weN, cke, done;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;

  always #4 clk = ~clk;  // 125 MHz

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WAIT_CKE(W_CKE), .WAIT_PRE(W_PRE),
    .WAIT_EXT(W_EXT), .WAIT_MODE(W_MODE), .WAIT_REF(W_REF)
  ) i_sdram_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .addr(addr), .bank(bank), .cke(cke), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int logN = 0;
  int logStamp [16];
  int logCmd   [16];
  int logAddr  [16];
  int logBank  [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && !csN && logN < 16) begin
      logStamp[logN] = cyc;
      logCmd[logN]   = {28'd0, csN, rasN, casN, weN};
      logAddr[logN]  = int'(addr);
      logBank[logN]  = int'(bank);
      logN = logN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(cke == 1'b0, req, "cke low", int'(cke), 0);
    check(done == 1'b0, req, "done low", int'(done), 0);
    check({csN, rasN, casN, weN} == 4'b1111, req, "deselect code",
          int'({csN, rasN, casN, weN}), 'hf);
    check(addr == '0 && bank == '0, req, "addr/bank zero",
          int'({addr, bank}), 0);
  endtask

  task automatic runSeq(input bit pulseMid, input string tag);
    int t0, doneCyc, guard, stamp;
    bit pulsed;
    int expCmd[NCMD], expAddr[NCMD], expBank[NCMD], expGap[NCMD];
    string rq[NCMD];
    expCmd  = '{'h2, 'h0, 'h0, 'h2, 'h1, 'h1, 'h0};
    expAddr = '{'h400, 'h000, 'h132, 'h400, 'h000, 'h000, 'h032};
    expBank = '{0, 1, 0, 0, 0, 0, 0};
    expGap  = '{W_CKE + 1, W_PRE + 1, W_EXT + 1, W_MODE + 1,
                W_PRE + 1, W_REF + 1, W_REF + 1};
    rq      = '{"R4", "R5", "R6", "R4", "R7", "R7", "R8"};
    pulsed = 1'b0;
    logN = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t0 = cyc;
    check(cke == 1'b1, "R2", {tag, " cke raised after start"}, int'(cke), 1);
    check(csN == 1'b1, "R2", {tag, " no command with cke step"}, int'(csN), 1);
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (pulseMid) begin
        if (start) start = 1'b0;
        else if (logN == 3 && !pulsed) begin start = 1'b1; pulsed = 1'b1; end
      end
    end
    start = 1'b0;
    doneCyc = cyc;
    check(logN == NCMD, "R9", {tag, " command count"}, logN, NCMD);
    stamp = t0;
    for (int i = 0; i < NCMD; i++) begin
      stamp = stamp + expGap[i];
      if (i < logN) begin
        check(logCmd[i] == expCmd[i], rq[i], $sformatf("%s cmd %0d code", tag, i),
              logCmd[i], expCmd[i]);
        check(logAddr[i] == expAddr[i], rq[i], $sformatf("%s cmd %0d addr", tag, i),
              logAddr[i], expAddr[i]);
        check(logBank[i] == expBank[i], rq[i], $sformatf("%s cmd %0d bank", tag, i),
              logBank[i], expBank[i]);
        check(logStamp[i] == stamp, "R10", $sformatf("%s cmd %0d stamp", tag, i),
              logStamp[i], stamp);
      end
    end
    check(doneCyc == stamp + W_MODE + 1, "R8", {tag, " done cycle"},
          doneCyc, stamp + W_MODE + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkIdle("R1 idle");

    // R9 R12: full run with a stray start pulse mid-sequence
    runSeq(1'b1, "run1");

    // R11 R12: start after done has no effect
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    check(logN == NCMD, "R11", "no command after done", logN, NCMD);
    check(done == 1'b1, "R11", "done held", int'(done), 1);
    check(cke == 1'b1, "R2", "cke held", int'(cke), 1);

    // R12: reset in the middle, then a fresh run
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkIdle("R12 after done reset");
    rstN = 1'b1;
    logN = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (logN < 2) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkIdle("R12 mid-run reset");
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    checkIdle("R1 idle after reset");
    runSeq(1'b0, "run2");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule